// File: doc/BRIEF.md
# Snooping Cache-Line Coherence Controller

This block keeps one private, direct-mapped cache coherent with its peers on a shared broadcast bus. Each line holds one word and one of four states: invalid, shared (clean, other caches may hold it), exclusive (clean, the only cached copy) and modified (the only copy, newer than memory). The block takes read and write requests from its processor and raises bus requests for misses, upgrades and write-backs. It also watches every transaction that other masters place on the bus. When such a transaction hits a line it holds, it reports sharing and supplies dirty data.

The processor request port is valid/ready. `cpu_req_ready` is low while a miss, upgrade or write-back is in progress, and in any cycle where `snp_valid` is high, so a snooped transaction is always ordered before a local access in the same cycle. Each accepted request produces a one-cycle `cpu_rsp_valid` pulse with no back-pressure. The bus request port is also valid/ready. Command, address and data stay stable until `bus_req_ready` is seen. The one exception is a snoop that removes the reason for the request: a pending invalidate is replaced by a read-for-ownership, and a pending write-back is dropped. The bus is atomic: no snoop arrives in a cycle where this block's request is granted or its fill returns.

Address layout: the low `IDX_W` bits select the line and the remaining bits are the tag. Bus addresses are full word addresses.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is 1, `bus_req_valid` and `cpu_rsp_valid` are 0, and no snoop sees a hit.
- R2: A read miss issues bus command 2'b00 (read) at the request address. When `bus_rsp_valid` arrives, the line fills exclusive if `bus_rsp_shared` is 0 and shared if it is 1. The fill data appears on `cpu_rsp_rdata` with `cpu_rsp_valid` one cycle later. No further bus request is made between the grant and the fill.
- R3: A read hit raises `cpu_rsp_valid` with the stored word in the cycle after acceptance, with no bus request.
- R4: A write hit on an exclusive or modified line completes in the cycle after acceptance with no bus request, and leaves the line modified.
- R5: A write hit on a shared line issues command 2'b10 (invalidate) at the line address. Once it is granted, the line becomes modified with the new word and the response follows.
- R6: A write miss issues command 2'b01 (read-for-ownership). When the fill arrives, the line is installed modified with the processor's word and the returned data is discarded.
- R7: A miss whose victim line is modified first issues command 2'b11 (write-back) carrying the victim's address and word, then the fill request.
- R8: A snooped read (2'b00) that hits a valid line raises `snp_shared`. On a modified line it also raises `snp_supply` and drives the word on `snp_data`. Exclusive and modified lines become shared.
- R9: A snooped read-for-ownership (2'b01) or invalidate (2'b10) that hits a valid line makes it invalid. A modified line first raises `snp_supply` with its word, and `snp_shared` stays 0.
- R10: A snooped write-back (2'b11), or a snoop whose tag misses, raises no response and changes no line.
- R11: While `bus_req_valid` is high without `bus_req_ready` and no snoop intervenes, the request and its command and address hold. `cpu_req_ready` is 0 while busy or while `snp_valid` is high.
- R12: A snoop that invalidates a line with a pending upgrade turns the request into a read-for-ownership. A snoop that takes a pending write-back victim out of the modified state cancels the write-back and the fill goes ahead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read word, or the written word |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_ready | input | 1 | Bus grant for the request |
| bus_req_cmd | output | 2 | 00 read, 01 read-for-ownership, 10 invalidate, 11 write-back |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_wdata | output | DATA_W | Write-back word |
| bus_rsp_valid | input | 1 | Fill data returned |
| bus_rsp_rdata | input | DATA_W | Fill word |
| bus_rsp_shared | input | 1 | Fill came from another cache |
| snp_valid | input | 1 | Another master's transaction on the bus |
| snp_cmd | input | 2 | Its command, same encoding |
| snp_addr | input | ADDR_W | Its address |
| snp_shared | output | 1 | This cache holds the line (read snoops) |
| snp_supply | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Supplied word |

## Verification
Two situations put a snoop and a local operation in the same cycle. In the first, a processor write and a snooped read for the same exclusive line arrive together. The bench checks that the request is held off and that the snoop reports shared without supplying data. The write must then go to the bus as an invalidate instead of completing silently. In the second, a snoop arrives while an upgrade or a write-back is waiting for its grant. The bench checks that the upgrade turns into a read-for-ownership, or that the write-back is cancelled and the fill read follows directly.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_E = 2'd2, LN_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BC_RD = 2'b00, BC_RFO = 2'b01, BC_INV = 2'b10, BC_WB = 2'b11} bus_cmd_t;
  typedef enum logic [2:0] {F_IDLE, F_UPG, F_WB, F_FILL, F_WAIT} ctl_fsm_t;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              snp_upd,
  input  line_st_t          snp_st,
  input  logic              ctl_upd,
  input  line_st_t          ctl_st,
  input  logic              ctl_tag_we,
  input  logic [TAG_W-1:0]  ctl_tag,
  input  logic              ctl_data_we,
  input  logic [DATA_W-1:0] ctl_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // Controller update is applied last, so it wins over a snoop on the same line.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_I;
    end else begin
      if (snp_upd) st_q[b_idx] <= snp_st;
      if (ctl_upd) st_q[a_idx] <= ctl_st;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl_tag_we)  tag_q[a_idx]  <= ctl_tag;
    if (ctl_data_we) data_q[a_idx] <= ctl_data;
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_t          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              upd,
  output line_st_t          new_st,
  output logic              shared_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] data_o
);
  logic hit, dirty;

  assign hit   = snp_valid && (line_st != LN_I) && (line_tag == snp_tag);
  assign dirty = hit && (line_st == LN_M);

  always_comb begin
    upd      = 1'b0;
    new_st   = line_st;
    shared_o = 1'b0;
    supply_o = 1'b0;
    case (snp_cmd)
      BC_RD: begin
        shared_o = hit;
        supply_o = dirty;
        upd      = hit && (line_st != LN_S);
        new_st   = LN_S;
      end
      BC_RFO, BC_INV: begin
        supply_o = dirty;
        upd      = hit;
        new_st   = LN_I;
      end
      default: ;
    endcase
  end

  assign data_o = supply_o ? line_data : '0;
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_rdata,
  input  logic              bus_rsp_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_fsm_t          fsm_q, fsm_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rsp_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  line_st_t          a_st, b_st, snp_new_st, ctl_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data, ctl_data, rsp_val;
  logic              snp_upd, ctl_upd, ctl_tag_we, ctl_data_we, rsp_set;
  logic              accept, tag_hit;

  assign cur_addr      = (fsm_q == F_IDLE) ? cpu_req_addr : addr_q;
  assign cur_idx       = cur_addr[IDX_W-1:0];
  assign cur_tag       = cur_addr[ADDR_W-1:IDX_W];
  assign cpu_req_ready = (fsm_q == F_IDLE) && !snp_valid;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign tag_hit       = (a_st != LN_I) && (a_tag == cur_tag);

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(cur_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(snp_addr[IDX_W-1:0]), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .snp_upd(snp_upd), .snp_st(snp_new_st),
    .ctl_upd(ctl_upd), .ctl_st(ctl_st),
    .ctl_tag_we(ctl_tag_we), .ctl_tag(cur_tag),
    .ctl_data_we(ctl_data_we), .ctl_data(ctl_data)
  );

  coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .line_st(b_st), .line_tag(b_tag), .line_data(b_data),
    .upd(snp_upd), .new_st(snp_new_st),
    .shared_o(snp_shared), .supply_o(snp_supply), .data_o(snp_data)
  );

  always_comb begin
    fsm_d         = fsm_q;
    ctl_upd       = 1'b0;
    ctl_st        = LN_I;
    ctl_tag_we    = 1'b0;
    ctl_data_we   = 1'b0;
    ctl_data      = wdata_q;
    rsp_set       = 1'b0;
    rsp_val       = wdata_q;
    bus_req_valid = 1'b0;
    bus_req_cmd   = BC_RD;
    bus_req_addr  = cur_addr;
    bus_req_wdata = '0;
    case (fsm_q)
      F_IDLE: begin
        if (accept) begin
          if (tag_hit && !cpu_req_we) begin
            rsp_set = 1'b1;
            rsp_val = a_data;
          end else if (tag_hit && (a_st == LN_M || a_st == LN_E)) begin
            ctl_upd     = 1'b1;
            ctl_st      = LN_M;
            ctl_data_we = 1'b1;
            ctl_data    = cpu_req_wdata;
            rsp_set     = 1'b1;
            rsp_val     = cpu_req_wdata;
          end else if (tag_hit) begin
            fsm_d = F_UPG;
          end else if (a_st == LN_M) begin
            fsm_d = F_WB;
          end else begin
            fsm_d = F_FILL;
          end
        end
      end
      F_UPG: begin
        if (tag_hit && a_st == LN_S) begin
          bus_req_valid = 1'b1;
          bus_req_cmd   = BC_INV;
          if (bus_req_ready) begin
            ctl_upd     = 1'b1;
            ctl_st      = LN_M;
            ctl_data_we = 1'b1;
            rsp_set     = 1'b1;
            fsm_d       = F_IDLE;
          end
        end else begin
          fsm_d = F_FILL;
        end
      end
      F_WB: begin
        if (a_st == LN_M) begin
          bus_req_valid = 1'b1;
          bus_req_cmd   = BC_WB;
          bus_req_addr  = {a_tag, cur_idx};
          bus_req_wdata = a_data;
          if (bus_req_ready) begin
            ctl_upd = 1'b1;
            ctl_st  = LN_I;
            fsm_d   = F_FILL;
          end
        end else begin
          fsm_d = F_FILL;
        end
      end
      F_FILL: begin
        bus_req_valid = 1'b1;
        bus_req_cmd   = we_q ? BC_RFO : BC_RD;
        if (bus_req_ready) fsm_d = F_WAIT;
      end
      F_WAIT: begin
        if (bus_rsp_valid) begin
          ctl_upd     = 1'b1;
          ctl_st      = we_q ? LN_M : (bus_rsp_shared ? LN_S : LN_E);
          ctl_tag_we  = 1'b1;
          ctl_data_we = 1'b1;
          ctl_data    = we_q ? wdata_q : bus_rsp_rdata;
          rsp_set     = 1'b1;
          rsp_val     = we_q ? wdata_q : bus_rsp_rdata;
          fsm_d       = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q      <= F_IDLE;
      we_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rsp_q      <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      fsm_q <= fsm_d;
      rsp_q <= rsp_set;
      if (rsp_set) rsp_data_q <= rsp_val;
      if (accept) begin
        we_q    <= cpu_req_we;
        addr_q  <= cpu_req_addr;
        wdata_q <= cpu_req_wdata;
      end
    end
  end

  assign cpu_rsp_valid = rsp_q;
  assign cpu_rsp_rdata = rsp_data_q;
endmodule

// File: rtl/coh_snoop_ctrl_chk.sv
module coh_snoop_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_shared,
  input logic              snp_supply,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [1:0]        bus_req_cmd,
  input logic [ADDR_W-1:0] bus_req_addr
);
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready && !snp_valid |=>
      bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr)); // R11

  AST_SHARED_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> snp_valid && snp_cmd == 2'b00); // R8

  AST_SUPPLY_ON_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_valid && snp_cmd != 2'b11); // R9

  AST_QUIET_AFTER_FILL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_ready && (bus_req_cmd == 2'b00 || bus_req_cmd == 2'b01) |=>
      !bus_req_valid); // R2
endmodule

bind coh_snoop_ctrl coh_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_shared(snp_shared), .snp_supply(snp_supply),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr)
);

// File: tb/coh_snoop_ctrl_bench.sv
module coh_snoop_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [7:0]  cpu_req_addr = '0;
  logic [15:0] cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [15:0] cpu_rsp_rdata;
  logic        bus_req_valid, bus_req_ready = 1'b0;
  logic [1:0]  bus_req_cmd;
  logic [7:0]  bus_req_addr;
  logic [15:0] bus_req_wdata;
  logic        bus_rsp_valid = 1'b0, bus_rsp_shared = 1'b0;
  logic [15:0] bus_rsp_rdata = '0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_cmd = '0;
  logic [7:0]  snp_addr = '0;
  logic        snp_shared, snp_supply;
  logic [15:0] snp_data;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [1:0] RD = 2'b00, RFO = 2'b01, INV = 2'b10, WB = 2'b11;

  always #10 clk = ~clk;

  coh_snoop_ctrl u_coh_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready), .bus_req_cmd(bus_req_cmd),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata), .bus_rsp_shared(bus_rsp_shared),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cpu_issue(input bit we, input logic [7:0] a, input logic [15:0] d);
    int w = 0;
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = d;
    while (!cpu_req_ready && w < 50) begin @(negedge clk); w++; end
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic bus_serve(input logic [1:0] cmd, input logic [7:0] a, input bit cd,
                           input logic [15:0] d, input string tag);
    int w = 0;
    while (!bus_req_valid && w < 50) begin @(negedge clk); w++; end
    chk(bus_req_valid, {tag, " bus valid"}, 32'(bus_req_valid), 1);
    chk(bus_req_cmd == cmd, {tag, " bus cmd"}, 32'(bus_req_cmd), 32'(cmd));
    chk(bus_req_addr == a, {tag, " bus addr"}, 32'(bus_req_addr), 32'(a));
    if (cd) chk(bus_req_wdata == d, {tag, " bus data"}, 32'(bus_req_wdata), 32'(d));
    bus_req_ready = 1'b1;
    @(negedge clk);
    bus_req_ready = 1'b0;
  endtask

  task automatic fill(input logic [15:0] d, input bit sh);
    bus_rsp_valid = 1'b1; bus_rsp_rdata = d; bus_rsp_shared = sh;
    @(negedge clk);
    bus_rsp_valid = 1'b0;
  endtask

  task automatic rsp_check(input logic [15:0] d, input string tag);
    chk(cpu_rsp_valid, {tag, " rsp valid"}, 32'(cpu_rsp_valid), 1);
    chk(cpu_rsp_rdata == d, {tag, " rsp data"}, 32'(cpu_rsp_rdata), 32'(d));
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] a, input bit esh,
                       input bit esup, input logic [15:0] ed, input string tag);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
    #1;
    chk(snp_shared == esh, {tag, " snp shared"}, 32'(snp_shared), 32'(esh));
    chk(snp_supply == esup, {tag, " snp supply"}, 32'(snp_supply), 32'(esup));
    if (esup) chk(snp_data == ed, {tag, " snp data"}, 32'(snp_data), 32'(ed));
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  // R1: reset state and empty snoop
  task automatic t_reset;
    chk(cpu_req_ready, "R1 ready", 32'(cpu_req_ready), 1);
    chk(!bus_req_valid, "R1 bus idle", 32'(bus_req_valid), 0);
    chk(!cpu_rsp_valid, "R1 rsp idle", 32'(cpu_rsp_valid), 0);
    snoop(RD, 8'h10, 1'b0, 1'b0, 16'h0, "R1 snoop after reset");
  endtask

  // R2 memory fill -> exclusive, R4 silent write, R8 snoop read, R3 read hit
  task automatic t_excl_path;
    cpu_issue(1'b0, 8'h04, 16'h0);
    bus_serve(RD, 8'h04, 1'b0, 16'h0, "R2 read miss");
    fill(16'h1111, 1'b0);
    rsp_check(16'h1111, "R2 fill");
    cpu_issue(1'b1, 8'h04, 16'h2222);
    chk(!bus_req_valid, "R4 no bus on E write", 32'(bus_req_valid), 0);
    rsp_check(16'h2222, "R4 write hit");
    snoop(RD, 8'h04, 1'b1, 1'b1, 16'h2222, "R8 snoop read on M");
    snoop(RD, 8'h04, 1'b1, 1'b0, 16'h0, "R8 now shared");
    cpu_issue(1'b0, 8'h04, 16'h0);
    chk(!bus_req_valid, "R3 no bus on hit", 32'(bus_req_valid), 0);
    rsp_check(16'h2222, "R3 read hit");
  endtask

  // R5 upgrade from shared, R9 snoop RFO on modified
  task automatic t_upgrade;
    cpu_issue(1'b1, 8'h04, 16'h3333);
    bus_serve(INV, 8'h04, 1'b0, 16'h0, "R5 upgrade");
    rsp_check(16'h3333, "R5 upgrade");
    snoop(RFO, 8'h04, 1'b0, 1'b1, 16'h3333, "R9 snoop rfo on M");
    snoop(RD, 8'h04, 1'b0, 1'b0, 16'h0, "R9 line invalid");
  endtask

  // R2 cache-sourced fill -> shared, R7 dirty victim
  task automatic t_shared_fill_and_victim;
    cpu_issue(1'b0, 8'h05, 16'h0);
    bus_serve(RD, 8'h05, 1'b0, 16'h0, "R2 read miss 2");
    fill(16'hAAAA, 1'b1);
    rsp_check(16'hAAAA, "R2 shared fill");
    cpu_issue(1'b1, 8'h05, 16'h5555);
    bus_serve(INV, 8'h05, 1'b0, 16'h0, "R2 shared fill needs invalidate");
    rsp_check(16'h5555, "R5 upgrade 2");
    cpu_issue(1'b0, 8'h09, 16'h0);
    bus_serve(WB, 8'h05, 1'b1, 16'h5555, "R7 victim write-back");
    bus_serve(RD, 8'h09, 1'b0, 16'h0, "R7 fill after write-back");
    fill(16'h9999, 1'b0);
    rsp_check(16'h9999, "R7 fill");
    snoop(RD, 8'h05, 1'b0, 1'b0, 16'h0, "R10 evicted tag misses");
  endtask

  // R6 write miss, R10 snoop write-back ignored
  task automatic t_write_miss;
    cpu_issue(1'b1, 8'h0A, 16'h7777);
    bus_serve(RFO, 8'h0A, 1'b0, 16'h0, "R6 write miss");
    fill(16'hDEAD, 1'b0);
    rsp_check(16'h7777, "R6 write miss");
    snoop(WB, 8'h0A, 1'b0, 1'b0, 16'h0, "R10 snoop write-back");
    snoop(RD, 8'h0A, 1'b1, 1'b1, 16'h7777, "R6 installed modified");
  endtask

  // R12 pending write-back cancelled by snoop
  task automatic t_wb_cancel;
    cpu_issue(1'b1, 8'h0A, 16'h8888);
    bus_serve(INV, 8'h0A, 1'b0, 16'h0, "R5 upgrade 3");
    rsp_check(16'h8888, "R5 upgrade 3");
    cpu_issue(1'b0, 8'h0E, 16'h0);
    chk(bus_req_valid && bus_req_cmd == WB, "R12 write-back pending", 32'(bus_req_cmd), 32'(WB));
    snoop(RD, 8'h0A, 1'b1, 1'b1, 16'h8888, "R12 snoop takes dirty data");
    bus_serve(RD, 8'h0E, 1'b0, 16'h0, "R12 fill without write-back");
    fill(16'hEEEE, 1'b0);
    rsp_check(16'hEEEE, "R12 fill");
    snoop(RD, 8'h0A, 1'b0, 1'b0, 16'h0, "R12 old line gone");
  endtask

  // R11 back-pressure on the bus request
  task automatic t_backpressure;
    cpu_issue(1'b0, 8'h0B, 16'h0);
    repeat (3) begin
      @(negedge clk);
      chk(bus_req_valid, "R11 held valid", 32'(bus_req_valid), 1);
      chk(bus_req_cmd == RD, "R11 held cmd", 32'(bus_req_cmd), 32'(RD));
      chk(bus_req_addr == 8'h0B, "R11 held addr", 32'(bus_req_addr), 32'h0B);
      chk(!cpu_req_ready, "R11 busy not ready", 32'(cpu_req_ready), 0);
    end
    bus_serve(RD, 8'h0B, 1'b0, 16'h0, "R11 grant");
    fill(16'hBBBB, 1'b0);
    rsp_check(16'hBBBB, "R11 fill");
  endtask

  // R11 snoop and processor write on the same line in one cycle
  task automatic t_same_cycle;
    cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = 8'h0B; cpu_req_wdata = 16'h4444;
    snp_valid = 1'b1; snp_cmd = RD; snp_addr = 8'h0B;
    #1;
    chk(!cpu_req_ready, "R11 stall during snoop", 32'(cpu_req_ready), 0);
    chk(snp_shared, "R8 exclusive snoop shared", 32'(snp_shared), 1);
    chk(!snp_supply, "R8 exclusive no supply", 32'(snp_supply), 0);
    @(negedge clk);
    snp_valid = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    bus_serve(INV, 8'h0B, 1'b0, 16'h0, "R11 write after snoop upgrades");
    rsp_check(16'h4444, "R11 write after snoop");
  endtask

  // R12 pending upgrade invalidated by another master
  task automatic t_upg_lost;
    snoop(RD, 8'h0B, 1'b1, 1'b1, 16'h4444, "R8 snoop read M 2");
    cpu_issue(1'b1, 8'h0B, 16'h6666);
    chk(bus_req_valid && bus_req_cmd == INV, "R12 upgrade pending", 32'(bus_req_cmd), 32'(INV));
    snoop(INV, 8'h0B, 1'b0, 1'b0, 16'h0, "R9 snoop invalidate on S");
    bus_serve(RFO, 8'h0B, 1'b0, 16'h0, "R12 upgrade becomes rfo");
    fill(16'h1234, 1'b0);
    rsp_check(16'h6666, "R12 rfo response");
    snoop(RD, 8'h0B, 1'b1, 1'b1, 16'h6666, "R12 line modified");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_excl_path();
    t_upgrade();
    t_shared_fill_and_victim();
    t_write_miss();
    t_wb_cancel();
    t_backpressure();
    t_same_cycle();
    t_upg_lost();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule